// File: doc/BRIEF.md
# Data Cache Maintenance Controller

This block handles the maintenance side of a small write-back data cache. It holds the valid, dirty and tag state of every line of a direct-mapped tag store. It carries out whole-cache and single-line writeback and invalidate commands, which arrive as register writes. A line that needs writing back goes to memory through a request/acknowledge port. The cache's normal fill path installs lines through a fill port. A probe port looks up an address and reports whether it hits and whether that line is dirty.

Software selects the invalidate behaviour with a mode bit in the control register. With the bit at 0, an invalidate discards lines. With the bit at 1, an invalidate first writes back each dirty line, then drops it. Any command that may write back lines sets the read-only busy bit, and the bit stays set until the last writeback has been acknowledged. Software polls the busy bit. Commands and fills that arrive while the block is busy are dropped.

Top module: `dcache_maint_ctrl`

## Requirements
- R1: After reset the control readback is 0: mode bit 0 is clear and busy bit 1 is clear. Every line reads as a miss and `wb_req` is low.
- R2: A write with `reg_sel`=0 loads `reg_wdata[0]` into the invalidate-mode bit, and `ctrl_rdata[0]` returns that bit.
- R3: A write with `reg_sel`=2 and `reg_wdata[0]`=1 writes back every valid dirty line, in ascending index order. Each writeback address is {tag, index, zero offset}. Afterwards those lines are clean and still valid.
- R4: A write with `reg_sel`=1 and `reg_wdata[0]`=1 while the mode bit is 0 makes every line invalid by the next cycle. It causes no memory traffic and never sets the busy bit.
- R5: The same whole-cache invalidate while the mode bit is 1 first writes back every dirty line in ascending index order, then leaves every line invalid.
- R6: `ctrl_rdata[1]` (busy) reads 1 from the cycle after a whole-cache writeback, a writeback-first whole invalidate, or a per-line command that needs a writeback. It returns to 0 after the last acknowledge.
- R7: Per-line commands take an address in `reg_wdata`: `reg_sel`=3 invalidates and `reg_sel`=4 writes back. They act only on the line whose index and tag both match. A per-line invalidate writes back a dirty line first when the mode bit is 1.
- R8: A per-line command that misses, or a per-line writeback of a clean line, produces no memory request, leaves the busy bit clear and changes no line.
- R9: Commands and fills presented while the busy bit is 1 have no effect.
- R10: `wb_req` stays high with `wb_addr` stable until the cycle in which `wb_ack` is sampled high.
- R11: A whole-cache command written with `reg_wdata[0]`=0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 control, 1 invalidate all, 2 writeback all, 3 invalidate line, 4 writeback line |
| reg_wdata | input | ADDR_W | Write data (mode bit, start bit or line address) |
| ctrl_rdata | output | 2 | Control readback: bit 1 busy, bit 0 invalidate mode |
| fill_en | input | 1 | Install a line |
| fill_addr | input | ADDR_W | Address of the installed line |
| fill_dirty | input | 1 | Dirty state of the installed line |
| probe_addr | input | ADDR_W | Lookup address |
| probe_hit | output | 1 | Lookup hits a valid line |
| probe_dirty | output | 1 | Hit line is dirty |
| wb_req | output | 1 | Line writeback request |
| wb_addr | output | ADDR_W | Line-aligned writeback address |
| wb_ack | input | 1 | Memory accepted the writeback |

## Verification
Each internal error is caught at a specific point. A bad index walk or a dirty bit that was not cleared shows up as missing, repeated or misordered writeback addresses, which the bench sees as they are acknowledged. A valid bit cleared wrongly, or one left set, shows up at the probe port on the first lookup after the command. A busy flag that falls early or rises late is caught one cycle after the command, or when the walk completes.

// File: rtl/dcache_maint_ctrl.sv
module dcache_maint_ctrl #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [1:0]        ctrl_rdata,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_dirty,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              probe_hit,
  output logic              probe_dirty,
  output logic              wb_req,
  output logic [ADDR_W-1:0] wb_addr,
  input  logic              wb_ack
);
  localparam int SETS  = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  localparam logic [2:0] SEL_CTRL    = 3'd0;
  localparam logic [2:0] SEL_INV_ALL = 3'd1;
  localparam logic [2:0] SEL_WB_ALL  = 3'd2;
  localparam logic [2:0] SEL_INV_LN  = 3'd3;
  localparam logic [2:0] SEL_WB_LN   = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_WB} state_t;

  state_t                 state;
  logic [SETS-1:0]        valid, dirty;
  logic [TAG_W-1:0]       tags [SETS];
  logic [IDX_W-1:0]       idx;
  logic                   inv_mode, op_inv, op_all;

  logic                   busy;
  logic [IDX_W-1:0]       cmd_idx, fill_idx, prb_idx;
  logic [TAG_W-1:0]       cmd_tag, fill_tag, prb_tag;
  logic                   cmd_hit;

  assign busy       = (state != S_IDLE);
  assign ctrl_rdata = {busy, inv_mode};

  assign cmd_idx  = reg_wdata[OFF_W +: IDX_W];
  assign cmd_tag  = reg_wdata[ADDR_W-1 -: TAG_W];
  assign fill_idx = fill_addr[OFF_W +: IDX_W];
  assign fill_tag = fill_addr[ADDR_W-1 -: TAG_W];
  assign prb_idx  = probe_addr[OFF_W +: IDX_W];
  assign prb_tag  = probe_addr[ADDR_W-1 -: TAG_W];

  assign cmd_hit     = valid[cmd_idx] && (tags[cmd_idx] == cmd_tag);
  assign probe_hit   = valid[prb_idx] && (tags[prb_idx] == prb_tag);
  assign probe_dirty = probe_hit && dirty[prb_idx];

  assign wb_req  = (state == S_WB);
  assign wb_addr = {tags[idx], idx, {OFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      valid    <= '0;
      dirty    <= '0;
      idx      <= '0;
      inv_mode <= 1'b0;
      op_inv   <= 1'b0;
      op_all   <= 1'b0;
      for (int i = 0; i < SETS; i++) tags[i] <= '0;
    end else begin
      if (reg_wr && reg_sel == SEL_CTRL) inv_mode <= reg_wdata[0];
      case (state)
        S_IDLE: begin
          if (fill_en) begin
            valid[fill_idx] <= 1'b1;
            dirty[fill_idx] <= fill_dirty;
            tags[fill_idx]  <= fill_tag;
          end
          if (reg_wr) begin
            case (reg_sel)
              SEL_INV_ALL: if (reg_wdata[0]) begin
                if (inv_mode) begin
                  state <= S_SCAN; idx <= '0; op_inv <= 1'b1; op_all <= 1'b1;
                end else begin
                  valid <= '0; dirty <= '0;
                end
              end
              SEL_WB_ALL: if (reg_wdata[0]) begin
                state <= S_SCAN; idx <= '0; op_inv <= 1'b0; op_all <= 1'b1;
              end
              SEL_INV_LN: if (cmd_hit) begin
                if (inv_mode && dirty[cmd_idx]) begin
                  state <= S_WB; idx <= cmd_idx; op_inv <= 1'b1; op_all <= 1'b0;
                end else begin
                  valid[cmd_idx] <= 1'b0; dirty[cmd_idx] <= 1'b0;
                end
              end
              SEL_WB_LN: if (cmd_hit && dirty[cmd_idx]) begin
                state <= S_WB; idx <= cmd_idx; op_inv <= 1'b0; op_all <= 1'b0;
              end
              default: ;
            endcase
          end
        end
        S_SCAN: begin
          if (valid[idx] && dirty[idx]) begin
            state <= S_WB;
          end else begin
            if (op_inv) valid[idx] <= 1'b0;
            if (&idx) state <= S_IDLE;
            else idx <= idx + 1'b1;
          end
        end
        S_WB: begin
          if (wb_ack) begin
            dirty[idx] <= 1'b0;
            if (op_inv) valid[idx] <= 1'b0;
            if (!op_all || &idx) state <= S_IDLE;
            else begin
              idx   <= idx + 1'b1;
              state <= S_SCAN;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_ack |=> wb_req && $stable(wb_addr));

  p_req_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> ctrl_rdata[1]);

  p_walk_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && op_all |-> (valid & dirty) == '0);

  p_wait_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_ack |=> $stable(valid));

  p_discard_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && reg_wr && reg_sel == SEL_INV_ALL && reg_wdata[0] && !inv_mode
    |=> !busy && valid == '0);
endmodule

// File: tb/dcache_maint_ctrl_tb_top.sv
module dcache_maint_ctrl_tb_top;
  localparam int ADDR_W = 16, IDX_W = 3, OFF_W = 4;
  localparam int SETS = 1 << IDX_W, TAG_W = ADDR_W - IDX_W - OFF_W;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0; logic [2:0] reg_sel = 0; logic [ADDR_W-1:0] reg_wdata = 0;
  logic [1:0] ctrl_rdata;
  logic fill_en = 0; logic [ADDR_W-1:0] fill_addr = 0; logic fill_dirty = 0;
  logic [ADDR_W-1:0] probe_addr = 0; logic probe_hit, probe_dirty;
  logic wb_req; logic [ADDR_W-1:0] wb_addr; logic wb_ack = 0;

  always #10 clk = ~clk;

  dcache_maint_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .ctrl_rdata(ctrl_rdata), .fill_en(fill_en), .fill_addr(fill_addr), .fill_dirty(fill_dirty),
    .probe_addr(probe_addr), .probe_hit(probe_hit), .probe_dirty(probe_dirty),
    .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic m_v [SETS]; logic m_d [SETS]; logic [TAG_W-1:0] m_t [SETS];
  logic m_mode = 0;
  logic [ADDR_W-1:0] exp_a [SETS]; int exp_n;
  logic [ADDR_W-1:0] cap_a [32]; int cap_n = 0;
  bit exp_busy;
  int dly = 0;

  always @(negedge clk) begin
    if (wb_ack) wb_ack <= 0;
    else if (wb_req) begin
      if (dly == 0) begin
        if (cap_n < 32) cap_a[cap_n] = wb_addr;
        cap_n = cap_n + 1;
        wb_ack <= 1;
        dly = $urandom % 3;
      end else dly = dly - 1;
    end
  end

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk(logic [TAG_W-1:0] t, int s);
    return {t, s[IDX_W-1:0], {OFF_W{1'b0}}};
  endfunction

  task automatic wb_line(int s, bit inv);
    if (m_v[s] && m_d[s]) begin exp_a[exp_n] = mk(m_t[s], s); exp_n++; end
    m_d[s] = 0;
    if (inv) m_v[s] = 0;
  endtask

  task automatic model(logic [2:0] sel, logic [ADDR_W-1:0] d);
    int s; bit hit;
    exp_n = 0; exp_busy = 0;
    s = int'(d[OFF_W +: IDX_W]);
    hit = m_v[s] && m_t[s] == d[ADDR_W-1 -: TAG_W];
    case (sel)
      0: m_mode = d[0];
      1: if (d[0]) begin
           if (m_mode) begin exp_busy = 1; for (int i = 0; i < SETS; i++) wb_line(i, 1); end
           else for (int i = 0; i < SETS; i++) begin m_v[i] = 0; m_d[i] = 0; end
         end
      2: if (d[0]) begin exp_busy = 1; for (int i = 0; i < SETS; i++) wb_line(i, 0); end
      3: if (hit) begin
           if (m_mode) wb_line(s, 1); else begin m_v[s] = 0; m_d[s] = 0; end
         end
      4: if (hit) wb_line(s, 0);
      default: ;
    endcase
    if (exp_n > 0) exp_busy = 1;
  endtask

  task automatic wr(logic [2:0] sel, logic [ADDR_W-1:0] d);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 200 && ctrl_rdata[1]; k++) @(negedge clk);
  endtask

  task automatic check_state(string req);
    int bad = 0;
    for (int s = 0; s < SETS; s++) begin
      probe_addr = mk(m_t[s], s);
      #1;
      if (probe_hit !== m_v[s] || probe_dirty !== (m_v[s] && m_d[s])) begin
        bad++;
        $display("FAIL %s set %0d actual hit/dirty=%0b%0b expected=%0b%0b",
                 req, s, probe_hit, probe_dirty, m_v[s], m_v[s] && m_d[s]);
      end
    end
    n_chk++;
    if (bad > 0) n_fail++;
  endtask

  task automatic check_traffic(string req);
    bit ok = (cap_n == exp_n);
    for (int i = 0; i < exp_n && ok; i++) if (cap_a[i] !== exp_a[i]) ok = 0;
    chk(ok, req, cap_n, exp_n);
    if (!ok) for (int i = 0; i < exp_n && i < cap_n; i++)
      if (cap_a[i] !== exp_a[i]) $display("FAIL %s entry %0d actual=%0h expected=%0h",
                                          req, i, cap_a[i], exp_a[i]);
  endtask

  task automatic op(logic [2:0] sel, logic [ADDR_W-1:0] d, string req);
    model(sel, d);
    cap_n = 0;
    wr(sel, d);
    chk(ctrl_rdata[1] == exp_busy, {req, " busy R6"}, ctrl_rdata[1], exp_busy);
    wait_idle();
    @(negedge clk);
    chk(ctrl_rdata == {1'b0, m_mode}, {req, " ctrl R2"}, ctrl_rdata, {1'b0, m_mode});
    check_traffic(req);
    check_state(req);
  endtask

  task automatic fill(int s, logic [TAG_W-1:0] t, bit d);
    fill_en = 1; fill_addr = mk(t, s); fill_dirty = d;
    @(negedge clk);
    fill_en = 0;
    m_v[s] = 1; m_t[s] = t; m_d[s] = d;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int s = 0; s < SETS; s++) begin m_v[s] = 0; m_d[s] = 0; m_t[s] = TAG_W'(s); end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(ctrl_rdata == 2'b00 && !wb_req, "R1 reset ctrl", {wb_req, ctrl_rdata}, 0);
    check_state("R1 all miss");

    // R2 mode bit
    op(0, 1, "R2 set mode");
    op(0, 0, "R2 clear mode");

    // R3 writeback all, ordered
    fill(5, 9'h011, 1); fill(1, 9'h022, 1); fill(3, 9'h033, 0);
    op(2, 1, "R3 wb all");
    // R11 start bit 0 ignored
    fill(2, 9'h044, 1);
    op(1, 0, "R11 inv all no start");
    op(2, 0, "R11 wb all no start");
    // R4 discard all
    op(1, 1, "R4 discard all");
    // R5 writeback-first invalidate all
    fill(0, 9'h055, 1); fill(7, 9'h066, 1); fill(4, 9'h077, 0);
    op(0, 1, "R5 mode");
    op(1, 1, "R5 inv all wb first");
    op(0, 0, "R5 restore mode");

    // R7 / R8 per-line
    fill(6, 9'h101, 1); fill(2, 9'h102, 1);
    op(4, mk(9'h1ff, 6), "R8 wb line tag miss");
    op(3, mk(9'h1ff, 2), "R8 inv line tag miss");
    op(4, mk(9'h101, 6), "R7 wb line hit");
    op(4, mk(9'h101, 6), "R8 wb line clean");
    op(0, 1, "R7 mode");
    op(3, mk(9'h102, 2), "R7 inv line wb first");
    op(0, 0, "R7 mode off");
    op(3, mk(9'h101, 6), "R7 inv line discard");

    // R9 commands and fills while busy ignored
    fill(1, 9'h0a1, 1); fill(3, 9'h0a3, 1);
    model(2, 1);
    cap_n = 0;
    wr(2, 1);
    chk(ctrl_rdata[1] == 1, "R9 busy", ctrl_rdata[1], 1);
    wr(1, 1);
    fill_en = 1; fill_addr = mk(9'h0bb, 5); fill_dirty = 1;
    @(negedge clk);
    fill_en = 0;
    wait_idle();
    @(negedge clk);
    check_traffic("R9 wb all under busy");
    check_state("R9 ignored cmd and fill");

    // random mix
    for (int it = 0; it < 60; it++) begin
      for (int f = 0; f < 3; f++)
        fill($urandom % SETS, TAG_W'($urandom % 2 + 1), $urandom % 2);
      if ($urandom % 4 == 0) op(0, ADDR_W'($urandom % 2), "R2 rnd mode");
      case ($urandom % 5)
        0: op(1, 1, "R4/R5 rnd inv all");
        1: op(2, 1, "R3 rnd wb all");
        2: op(3, mk(TAG_W'($urandom % 2 + 1), $urandom % SETS), "R7 rnd inv line");
        3: op(4, mk(TAG_W'($urandom % 2 + 1), $urandom % SETS), "R7 rnd wb line");
        default: op(3'd5 + 3'($urandom % 3), 1, "R8 rnd unused sel");
      endcase
    end

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule